// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Command Sequencer

This block controls one DRAM bank. It takes one read or write request at a time, addressed by a row and a column. It then emits the commands that the bank's row buffer needs to serve that request. The block records whether a row is held open and which row that is. Each accepted request is classed as one of three cases:

- **Closed:** no row is open.
- **Hit:** the open row matches the request.
- **Conflict:** a different row is open.

The class sets the command sequence. A hit needs only the column command. A closed bank first needs an activate. A conflict first needs a precharge of the old row.

A page-policy input is sampled with each request. Under the open policy the row is left open after the access. Under the closed policy the row is precharged right after the column command. The exception is when the requester sets a hint saying that a later queued request targets the same row. Two minimum gaps are parameters and are kept for every command, including across request boundaries:

- activate to column command;
- column command to precharge.

Commands leave the block as early as those gaps allow. A one-cycle pulse marks the end of each sequence.

Top module: `rbuf_bank_seq`

## Requirements
- R1: After reset, req_ready_o is 1 and cmd_valid_o, done_o and class_valid_o are 0. No row is open, so the first request is classed as closed.
- R2: Each accepted request is classed as 2'b00 closed (no row open), 2'b01 hit (open row equals the request row) or 2'b10 conflict (another row open). The class is shown on class_o while class_valid_o is 1.
- R3: A request to a closed bank issues activate (op 2'b00) of the request row, then the column command. The column command is read (op 2'b01) or write (op 2'b10) as chosen by req_write_i, and carries the request column.
- R4: A hit issues the column command alone, with no activate and no precharge.
- R5: A conflict issues precharge (op 2'b11) carrying the old open row, then activate of the new row, then the column command.
- R6: Under the closed policy (policy_closed_i = 1) with the hint low, a precharge of the request row follows the column command, and the bank is closed afterwards.
- R7: Under the closed policy with the hint high, and always under the open policy, the row stays open after the column command. A following request to that row is then a hit.
- R8: A column command is issued exactly T_RCD cycles after the activate before it.
- R9: A precharge is issued exactly T_RTP cycles after the latest column command, or in the first cycle after acceptance when that is later. This holds across request boundaries.
- R10: In a conflict, the activate is issued in the cycle right after the precharge.
- R11: class_valid_o pulses for the single cycle after acceptance. done_o pulses for the single cycle after the last command of a sequence, and req_ready_o is 1 again in that same cycle.
- R12: req_ready_o is 0 and no request is taken from acceptance until done_o. No command is issued while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| policy_closed_i | input | 1 | Page policy for the request: 1 closed, 0 open |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request taken when valid |
| req_row_i | input | ROW_W | Request row |
| req_col_i | input | COL_W | Request column |
| req_write_i | input | 1 | 1 write, 0 read |
| req_keep_i | input | 1 | Hint: a later queued request targets the same row |
| cmd_valid_o | output | 1 | Command issued this cycle |
| cmd_op_o | output | 2 | 00 activate, 01 read, 10 write, 11 precharge |
| cmd_row_o | output | ROW_W | Row for activate/precharge (and target row for column commands) |
| cmd_col_o | output | COL_W | Column for read/write |
| class_valid_o | output | 1 | Class of the latest accepted request is valid |
| class_o | output | 2 | 00 closed, 01 hit, 10 conflict |
| done_o | output | 1 | Sequence finished |

## Verification
A stale open-row flag or a wrong stored row shows up at once on class_o, in the cycle after the next request is accepted. It also shows up in that request's command list, such as a missing activate or a precharge carrying the wrong row. A gap counter that loads or decrements wrongly moves a command by one or more cycles. The bench catches this because it predicts the exact issue cycle of every command from the two gaps and the idle time between requests. Policy and hint faults surface one request later, as a hit where a closed class was expected, or the reverse.

// File: rtl/rbuf_pkg.sv
// Shared command and class encodings for the bank sequencer.
// Assumes: encodings are fixed and visible at the ports.
package rbuf_pkg;

    typedef enum logic [1:0] {
        OP_ACT = 2'b00,
        OP_RD  = 2'b01,
        OP_WR  = 2'b10,
        OP_PRE = 2'b11
    } cmd_op_e;

    typedef enum logic [1:0] {
        CLS_CLOSED   = 2'b00,
        CLS_HIT      = 2'b01,
        CLS_CONFLICT = 2'b10
    } row_class_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_ACT,
        S_COL,
        S_CLOSE
    } seq_state_e;

endpackage

// File: rtl/rbuf_classify.sv
// Classifies a request row against the row-buffer state.
// Assumes: open_row_i is meaningful only while open_i is 1.
module rbuf_classify
    import rbuf_pkg::*;
#(
    parameter int ROW_W = 14
) (
    input  logic             open_i,
    input  logic [ROW_W-1:0] open_row_i,
    input  logic [ROW_W-1:0] req_row_i,
    output row_class_e       class_o
);

    // Purpose: pick closed, hit or conflict from the open flag and the row compare.
    always_comb begin
        if (!open_i)
            class_o = CLS_CLOSED;
        else if (open_row_i == req_row_i)
            class_o = CLS_HIT;
        else
            class_o = CLS_CONFLICT;
    end

endmodule

// File: rtl/rbuf_gap_timer.sv
// Down-counter enforcing a minimum spacing of GAP cycles after an event.
// Assumes: GAP >= 1; clear_o is 1 when GAP cycles have passed since start_i.
module rbuf_gap_timer #(
    parameter int GAP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic clear_o
);

    localparam int CW = $clog2(GAP) + 1;
    localparam logic [CW-1:0] LOAD = CW'(GAP - 1);

    logic [CW-1:0] cnt_q;

    // Purpose: load on the event, count down to zero, hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start_i)
            cnt_q <= LOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign clear_o = (cnt_q == '0);

endmodule

// File: rtl/rbuf_bank_seq.sv
// Per-bank row-buffer command sequencer.
// Takes one request at a time, classes it against the open row and walks
// precharge / activate / column / closing-precharge as required, issuing each
// command as soon as the activate-to-column and column-to-precharge gaps allow.
// Assumes: T_RCD >= 1, T_RTP >= 1; policy and hint are sampled at acceptance.
module rbuf_bank_seq
    import rbuf_pkg::*;
#(
    parameter int ROW_W = 14,
    parameter int COL_W = 10,
    parameter int T_RCD = 4,
    parameter int T_RTP = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             policy_closed_i,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic [ROW_W-1:0] req_row_i,
    input  logic [COL_W-1:0] req_col_i,
    input  logic             req_write_i,
    input  logic             req_keep_i,
    output logic             cmd_valid_o,
    output logic [1:0]       cmd_op_o,
    output logic [ROW_W-1:0] cmd_row_o,
    output logic [COL_W-1:0] cmd_col_o,
    output logic             class_valid_o,
    output logic [1:0]       class_o,
    output logic             done_o
);

    seq_state_e       state_q;
    logic             open_q;
    logic [ROW_W-1:0] open_row_q;
    logic [ROW_W-1:0] tgt_row_q;
    logic [COL_W-1:0] col_q;
    logic             wr_q;
    logic             close_after_q;
    row_class_e       cls_now;
    row_class_e       cls_q;
    logic             cls_vld_q;
    logic             done_q;
    logic             act_clear;
    logic             col_clear;
    logic             accept;
    logic             issue;
    logic             issue_act;
    logic             issue_col;
    cmd_op_e          op_now;

    rbuf_classify #(.ROW_W(ROW_W)) u_cls (
        .open_i     (open_q),
        .open_row_i (open_row_q),
        .req_row_i  (req_row_i),
        .class_o    (cls_now)
    );

    rbuf_gap_timer #(.GAP(T_RCD)) u_rcd (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (issue_act),
        .clear_o (act_clear)
    );

    rbuf_gap_timer #(.GAP(T_RTP)) u_rtp (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (issue_col),
        .clear_o (col_clear)
    );

    assign req_ready_o = (state_q == S_IDLE);
    assign accept      = req_ready_o && req_valid_i;

    // Purpose: decide whether the command of the current state may go out.
    always_comb begin
        case (state_q)
            S_PRE, S_CLOSE: issue = col_clear;
            S_ACT:          issue = 1'b1;
            S_COL:          issue = act_clear;
            default:        issue = 1'b0;
        endcase
    end

    // Purpose: map state to command code.
    always_comb begin
        case (state_q)
            S_ACT:   op_now = OP_ACT;
            S_COL:   op_now = wr_q ? OP_WR : OP_RD;
            default: op_now = OP_PRE;
        endcase
    end

    assign issue_act   = issue && (state_q == S_ACT);
    assign issue_col   = issue && (state_q == S_COL);
    assign cmd_valid_o = issue;
    assign cmd_op_o    = op_now;
    assign cmd_row_o   = (state_q == S_PRE) ? open_row_q : tgt_row_q;
    assign cmd_col_o   = col_q;

    // Purpose: latch the request and choose the first command state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_row_q     <= '0;
            col_q         <= '0;
            wr_q          <= 1'b0;
            close_after_q <= 1'b0;
            cls_q         <= CLS_CLOSED;
            cls_vld_q     <= 1'b0;
        end else begin
            cls_vld_q <= accept;
            if (accept) begin
                tgt_row_q     <= req_row_i;
                col_q         <= req_col_i;
                wr_q          <= req_write_i;
                close_after_q <= policy_closed_i && !req_keep_i;
                cls_q         <= cls_now;
            end
        end
    end

    // Purpose: sequence states and track the open row as commands issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            open_q     <= 1'b0;
            open_row_q <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: if (accept) begin
                    case (cls_now)
                        CLS_HIT:      state_q <= S_COL;
                        CLS_CONFLICT: state_q <= S_PRE;
                        default:      state_q <= S_ACT;
                    endcase
                end
                S_PRE: if (issue) begin
                    open_q  <= 1'b0;
                    state_q <= S_ACT;
                end
                S_ACT: begin
                    open_q     <= 1'b1;
                    open_row_q <= tgt_row_q;
                    state_q    <= S_COL;
                end
                S_COL: if (issue) begin
                    if (close_after_q) begin
                        state_q <= S_CLOSE;
                    end else begin
                        state_q <= S_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                S_CLOSE: if (issue) begin
                    open_q  <= 1'b0;
                    state_q <= S_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign class_valid_o = cls_vld_q;
    assign class_o       = cls_q;
    assign done_o        = done_q;

    // Independent age counters used only by the assertions below.
    localparam int AW = $clog2(T_RCD + T_RTP + 1) + 1;
    logic [AW-1:0] act_age_q;
    logic [AW-1:0] col_age_q;

    // Purpose: saturating cycle counts since the last activate / column command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_age_q <= AW'(T_RCD);
            col_age_q <= AW'(T_RTP);
        end else begin
            if (cmd_valid_o && cmd_op_o == OP_ACT)
                act_age_q <= AW'(1);
            else if (act_age_q < AW'(T_RCD))
                act_age_q <= act_age_q + 1'b1;
            if (cmd_valid_o && (cmd_op_o == OP_RD || cmd_op_o == OP_WR))
                col_age_q <= AW'(1);
            else if (col_age_q < AW'(T_RTP))
                col_age_q <= col_age_q + 1'b1;
        end
    end

    p_rcd_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && (cmd_op_o == OP_RD || cmd_op_o == OP_WR)) |-> act_age_q >= AW'(T_RCD));

    p_rtp_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_op_o == OP_PRE) |-> col_age_q >= AW'(T_RTP));

    p_idle_silent_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> !cmd_valid_o);

    p_done_after_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(cmd_valid_o) && req_ready_o));

    p_act_on_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_op_o == OP_ACT) |-> !open_q);

    p_pre_then_act_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_op_o == OP_PRE && !req_ready_o && state_q == S_PRE)
        |=> (cmd_valid_o && cmd_op_o == OP_ACT));

endmodule

// File: tb/rbuf_bank_seq_tb.sv
module rbuf_bank_seq_tb;

    localparam int ROW_W = 3;
    localparam int COL_W = 3;
    localparam int T_RCD = 3;
    localparam int T_RTP = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             policy_closed_i = 1'b0;
    logic             req_valid_i = 1'b0;
    logic             req_ready_o;
    logic [ROW_W-1:0] req_row_i = '0;
    logic [COL_W-1:0] req_col_i = '0;
    logic             req_write_i = 1'b0;
    logic             req_keep_i = 1'b0;
    logic             cmd_valid_o;
    logic [1:0]       cmd_op_o;
    logic [ROW_W-1:0] cmd_row_o;
    logic [COL_W-1:0] cmd_col_o;
    logic             class_valid_o;
    logic [1:0]       class_o;
    logic             done_o;

    always #2 clk = ~clk;

    rbuf_bank_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_RTP(T_RTP)) u_dut (
        .clk(clk), .rst_n(rst_n), .policy_closed_i(policy_closed_i),
        .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
        .req_row_i(req_row_i), .req_col_i(req_col_i), .req_write_i(req_write_i),
        .req_keep_i(req_keep_i), .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o),
        .cmd_row_o(cmd_row_o), .cmd_col_o(cmd_col_o), .class_valid_o(class_valid_o),
        .class_o(class_o), .done_o(done_o)
    );

    int  checks = 0;
    int  failures = 0;
    int  n = 0;
    bit  finished = 0;
    bit  m_open = 0;
    int  m_row = 0;
    int  last_col = -100;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, n);
        end
    endtask

    task automatic step();
        @(negedge clk);
        n++;
    endtask

    task automatic do_req(input int row, input int col, input bit wr, input bit keep,
                          input bit pol, input int idle);
        int e_op[4];
        int e_row[4];
        int e_t[4];
        int cnt;
        int cls;
        int k;
        int idx;
        int t;
        bit seen_done;
        for (int i = 0; i < idle; i++) begin
            step();
            chk(cmd_valid_o == 1'b0, "R12 idle silent", int'(cmd_valid_o), 0);
        end
        policy_closed_i = pol;
        req_row_i = ROW_W'(row);
        req_col_i = COL_W'(col);
        req_write_i = wr;
        req_keep_i = keep;
        req_valid_i = 1'b1;
        k = n;
        chk(req_ready_o == 1'b1, "R11 ready before request", int'(req_ready_o), 1);
        // expected sequence from the row-buffer model
        cls = !m_open ? 0 : (m_row == row ? 1 : 2);
        cnt = 0;
        t = k + 1;
        if (cls == 2) begin
            if (last_col + T_RTP > t) t = last_col + T_RTP;
            e_op[cnt] = 3; e_row[cnt] = m_row; e_t[cnt] = t; cnt++;
            t = t + 1;
        end
        if (cls != 1) begin
            e_op[cnt] = 0; e_row[cnt] = row; e_t[cnt] = t; cnt++;
            t = t + T_RCD;
        end
        e_op[cnt] = wr ? 2 : 1; e_row[cnt] = row; e_t[cnt] = t; cnt++;
        last_col = t;
        if (pol && !keep) begin
            t = t + T_RTP;
            e_op[cnt] = 3; e_row[cnt] = row; e_t[cnt] = t; cnt++;
            m_open = 0;
        end else begin
            m_open = 1;
            m_row = row;
        end
        step();
        req_valid_i = 1'b0;
        chk(class_valid_o == 1'b1, "R11 class pulse", int'(class_valid_o), 1);
        chk(int'(class_o) == cls, "R2 class", int'(class_o), cls);
        idx = 0;
        seen_done = 0;
        for (int w = 0; w < 40 && !seen_done; w++) begin
            if (w > 0) begin
                chk(class_valid_o == 1'b0, "R11 class single", int'(class_valid_o), 0);
            end
            if (cmd_valid_o) begin
                if (idx < cnt) begin
                    chk(int'(cmd_op_o) == e_op[idx], "R3/R4/R5/R6 op", int'(cmd_op_o), e_op[idx]);
                    chk(int'(cmd_row_o) == e_row[idx], "R5 row", int'(cmd_row_o), e_row[idx]);
                    chk(n == e_t[idx], "R8/R9/R10 timing", n, e_t[idx]);
                    if (e_op[idx] == 1 || e_op[idx] == 2)
                        chk(int'(cmd_col_o) == col, "R3 column", int'(cmd_col_o), col);
                end else begin
                    chk(1'b0, "R4 extra command", idx + 1, cnt);
                end
                idx++;
            end
            if (done_o) begin
                seen_done = 1;
                chk(idx == cnt, "R4/R6 command count", idx, cnt);
                chk(n == e_t[cnt-1] + 1, "R11 done timing", n, e_t[cnt-1] + 1);
                chk(req_ready_o == 1'b1, "R11 ready with done", int'(req_ready_o), 1);
            end else begin
                chk(req_ready_o == 1'b0, "R12 busy", int'(req_ready_o), 0);
                step();
            end
        end
        if (!seen_done) chk(1'b0, "R11 done missing", 0, 1);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int prev;
        int row;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk(req_ready_o == 1'b1, "R1 ready", int'(req_ready_o), 1);
        chk(cmd_valid_o == 1'b0, "R1 cmd", int'(cmd_valid_o), 0);
        chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
        chk(class_valid_o == 1'b0, "R1 class", int'(class_valid_o), 0);
        // first request must be classed closed (R1)
        do_req(5, 2, 1'b0, 1'b0, 1'b0, 0);
        prev = 5;
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 32; i++) begin
                row = (i % 3 == 2) ? prev : ((i * 5 + p * 3 + i / 7) % 8);
                // R7: hint on bit 1 of i; hint ignored under open policy
                do_req(row, i % 8, i[0], i[1], p[0], i % 3);
                prev = row;
            end
        end
        // mixed policy switches without reset
        for (int i = 0; i < 16; i++) begin
            row = (i % 2 == 0) ? prev : (i * 3) % 8;
            do_req(row, (i * 3) % 8, i[1], i[2], i[0], (i * 2) % 5);
            prev = row;
        end
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule